// File: doc/BRIEF.md
# Key-Memory Access Pattern Monitor

This block sits beside a crypto engine and passively snoops its address bus. Every observed access is sorted into one of two classes: a key-memory access, when the address falls inside a programmable window, or any other access. Consecutive accesses of one class form a run. The monitor compares each run length against a small table of expected lengths. The table begins with an opening section, which covers the key-schedule phase. It then has a repeat section, which describes the traffic of one encrypted block. The repeat section is replayed for as many blocks as arrive, because the number of blocks is not known beforehand. Only access counts are compared; the individual key addresses are not.

A second, independent check flags any key-memory access made while the engine reports that no encryption is in progress. This is a sign that the key store is being read by something other than the cipher. Both findings set bits in a sticky cause code, and that code stays set until software clears it.

The snoop port carries a valid strobe and an address and has no ready signal. The monitor observes traffic and never applies back-pressure, so a transfer counts on every cycle in which `snoop_valid` is high. The window bounds and the profile table are loaded while `mon_en` is low and are held stable while monitoring is enabled.

Top module: `keymon_top`

## Requirements
- R1: An access is a key access exactly when `win_base <= snoop_addr <= win_limit`, compared as unsigned numbers with both bounds inclusive. Every other address is a non-key access.
- R2: Profile entry i holds the expected length of the i-th run. Even indices describe non-key runs and odd indices describe key runs, and checking starts at entry 0 with an empty non-key run. An access stream whose completed runs all equal their entries leaves `alarm_cause` at 2'b00.
- R3: When a run ends (an access of the other class arrives) with fewer accesses than its entry, bit 0 of `alarm_cause` (sequence mismatch) is set. It is visible in the cycle after the edge that sampled the closing access.
- R4: When a run grows past its entry, bit 0 of `alarm_cause` is set by the access that exceeds the entry, without waiting for the run to end.
- R5: After the entry at `prof_last_idx`, checking continues at `prof_rep_idx`. It repeats without limit, so the per-block pattern is reapplied for every block. `prof_rep_idx` is even and `prof_last_idx` is odd.
- R6: A key access while `mon_en` is high and `enc_active` is low sets bit 1 of `alarm_cause` (key access while idle), whatever the state of the sequence check.
- R7: Cause bits are sticky and accumulate. `alarm_clr` clears them, but an event sampled in the same cycle as `alarm_clr` is still recorded. `alarm` is high whenever any cause bit is set.
- R8: After a mismatch, sequence checking is suspended. `alarm_clr`, or `mon_en` low, restarts it at entry 0 with an empty run. The sequence check ignores an access sampled in the restart cycle.
- R9: While `mon_en` is low, accesses raise no alarm. After reset, `alarm` is 0 and `alarm_cause` is 2'b00.
- R10: Cycles with `snoop_valid` low neither extend nor end a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_en | input | 1 | Monitoring enable; low holds the sequence check at entry 0 |
| enc_active | input | 1 | High while the engine is encrypting |
| alarm_clr | input | 1 | Clears the cause bits and restarts the sequence check |
| win_base | input | ADDR_W | Lowest key-memory address (inclusive) |
| win_limit | input | ADDR_W | Highest key-memory address (inclusive) |
| prof_wr_en | input | 1 | Profile table write strobe |
| prof_wr_idx | input | IDX_W | Profile entry to write |
| prof_wr_len | input | LEN_W | Expected run length to write |
| prof_last_idx | input | IDX_W | Index of the final entry of the repeat section |
| prof_rep_idx | input | IDX_W | Index where the repeat section begins |
| snoop_valid | input | 1 | An access is on the bus this cycle |
| snoop_addr | input | ADDR_W | Address of the observed access |
| alarm | output | 1 | Any cause bit set |
| alarm_cause | output | 2 | Bit 0: sequence mismatch; bit 1: key access while idle |

## Verification
Several properties are checked on every cycle. A restart always returns the sequence check to entry 0 with an empty run. A suspended check keeps its pointer and run length frozen. A sampled mismatch or idle-time key access always shows up in the cause bits one cycle later. Cause bits only clear through `alarm_clr`. The bench scenarios cover behaviour that needs a whole access history. These include the full key-schedule phase followed by several repeated blocks, a key run cut short, a non-key run that grows too long, and window boundaries at one address either side. They also include idle gaps inside runs, a clear arriving together with an event, and accesses made while monitoring is off.

// File: rtl/keymon_pkg.sv
package keymon_pkg;
  // Cause code: bit 1 = key access while idle, bit 0 = sequence mismatch
  typedef struct packed {
    logic idle_key;
    logic seq_err;
  } cause_t;
endpackage

// File: rtl/keymon_classify.sv
module keymon_classify #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic              in_win
);
  // R1: inclusive unsigned window
  always_comb in_win = (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/keymon_profile.sv
module keymon_profile #(
  parameter int DEPTH = 8,
  parameter int LEN_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [LEN_W-1:0] wr_len,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [LEN_W-1:0] rd_a_len,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [LEN_W-1:0] rd_b_len
);
  logic [LEN_W-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ent[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g)) ent[g] <= wr_len;
    end
  end

  always_comb begin
    rd_a_len = ent[rd_a_idx];
    rd_b_len = ent[rd_b_idx];
  end
endmodule

// File: rtl/keymon_seq.sv
module keymon_seq #(
  parameter int DEPTH = 8,
  parameter int LEN_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             acc,
  input  logic             acc_key,
  input  logic [IDX_W-1:0] last_idx,
  input  logic [IDX_W-1:0] rep_idx,
  input  logic [LEN_W-1:0] exp_cur,
  input  logic [LEN_W-1:0] exp_nxt,
  output logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] nxt_ptr,
  output logic             mismatch
);
  logic [LEN_W-1:0] run_len;
  logic [LEN_W:0]   grown;
  logic             halted;
  logic             same_kind;

  always_comb begin
    // R2: entry parity gives the run class (odd = key)
    same_kind = (acc_key == ptr[0]);
    grown     = {1'b0, run_len} + 1'b1;
    // R5: wrap from last entry back to the repeat section
    nxt_ptr   = (ptr == last_idx) ? rep_idx : ptr + 1'b1;
    mismatch  = 1'b0;
    if (acc && !restart && !halted) begin
      if (same_kind) mismatch = (grown > {1'b0, exp_cur});          // R4
      else           mismatch = (run_len != exp_cur) || (exp_nxt == '0); // R3
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      run_len <= '0;
      halted  <= 1'b0;
    end else if (restart) begin
      ptr     <= '0;
      run_len <= '0;
      halted  <= 1'b0;
    end else if (acc && !halted) begin
      if (mismatch) begin
        halted <= 1'b1;
      end else if (same_kind) begin
        run_len <= grown[LEN_W-1:0];
      end else begin
        ptr     <= nxt_ptr;
        run_len <= LEN_W'(1);
      end
    end
  end

  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ptr == '0 && run_len == '0 && !halted));

  assert_halt_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !restart) |=> (halted && $stable(ptr) && $stable(run_len)));

  assert_mismatch_suspends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> halted);

  assert_idle_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !restart) |=> ($stable(ptr) && $stable(run_len)));
endmodule

// File: rtl/keymon_alarm.sv
module keymon_alarm
  import keymon_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  cause_t evt,
  output cause_t cause
);
  // R7: clear first, then merge this cycle's events
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause <= '0;
    else        cause <= (clr ? cause_t'('0) : cause) | evt;
  end

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((cause | $past(cause)) == cause));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt == '0) |=> (cause == '0));
endmodule

// File: rtl/keymon_top.sv
module keymon_top
  import keymon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_en,
  input  logic              enc_active,
  input  logic              alarm_clr,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_limit,
  input  logic              prof_wr_en,
  input  logic [IDX_W-1:0]  prof_wr_idx,
  input  logic [LEN_W-1:0]  prof_wr_len,
  input  logic [IDX_W-1:0]  prof_last_idx,
  input  logic [IDX_W-1:0]  prof_rep_idx,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              alarm,
  output logic [1:0]        alarm_cause
);
  logic             is_key;
  logic             acc;
  logic             restart;
  logic [IDX_W-1:0] ptr, nxt_ptr;
  logic [LEN_W-1:0] exp_cur, exp_nxt;
  logic             seq_mis;
  cause_t           evt, cause;

  keymon_classify #(.ADDR_W(ADDR_W)) u_cls (
    .addr(snoop_addr), .lo(win_base), .hi(win_limit), .in_win(is_key));

  keymon_profile #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_prof (
    .clk(clk), .rst_n(rst_n),
    .wr_en(prof_wr_en), .wr_idx(prof_wr_idx), .wr_len(prof_wr_len),
    .rd_a_idx(ptr), .rd_a_len(exp_cur),
    .rd_b_idx(nxt_ptr), .rd_b_len(exp_nxt));

  always_comb begin
    acc          = snoop_valid && mon_en;      // R9
    restart      = !mon_en || alarm_clr;       // R8
    evt.seq_err  = seq_mis;
    evt.idle_key = acc && is_key && !enc_active; // R6
  end

  keymon_seq #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .acc(acc), .acc_key(is_key),
    .last_idx(prof_last_idx), .rep_idx(prof_rep_idx),
    .exp_cur(exp_cur), .exp_nxt(exp_nxt),
    .ptr(ptr), .nxt_ptr(nxt_ptr), .mismatch(seq_mis));

  keymon_alarm u_alm (
    .clk(clk), .rst_n(rst_n), .clr(alarm_clr), .evt(evt), .cause(cause));

  always_comb begin
    alarm_cause = cause;
    alarm       = |cause;
  end

  assert_idle_key_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && mon_en && is_key && !enc_active) |=> alarm_cause[1]);

  assert_mismatch_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_mis |=> alarm_cause[0]);

  assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en && alarm_clr) |=> (alarm_cause == 2'b00));

  assert_alarm_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm == (alarm_cause != 2'b00));
endmodule

// File: tb/keymon_top_tb_top.sv
module keymon_top_tb_top;
  localparam int AW = 16;
  localparam int DEPTH = 8;
  localparam int LW = 8;
  localparam int IW = $clog2(DEPTH);
  localparam logic [AW-1:0] BASE = 16'h1000;
  localparam logic [AW-1:0] LIM  = 16'h10FF;
  localparam logic [AW-1:0] NK_A = 16'h2000;

  // segment: {key, count, enc, expected cause after segment}
  localparam int NSEG = 11;
  localparam logic [11:0] SEG [0:NSEG-1] = '{
    {1'b0, 8'd3,  1'b1, 2'b00},   // opening non-key run
    {1'b1, 8'd4,  1'b1, 2'b00},   // key schedule
    {1'b0, 8'd2,  1'b1, 2'b00},   // block 1
    {1'b1, 8'd10, 1'b1, 2'b00},
    {1'b0, 8'd2,  1'b1, 2'b00},   // block 2
    {1'b1, 8'd10, 1'b1, 2'b00},
    {1'b0, 8'd2,  1'b1, 2'b00},   // block 3
    {1'b1, 8'd10, 1'b1, 2'b00},
    {1'b0, 8'd2,  1'b1, 2'b00},   // block 4
    {1'b1, 8'd9,  1'b1, 2'b00},   // short key run, still open
    {1'b0, 8'd1,  1'b1, 2'b01}    // closes it: mismatch
  };

  logic clk = 0, rst_n = 0;
  logic mon_en = 0, enc_active = 0, alarm_clr = 0;
  logic prof_wr_en = 0;
  logic [IW-1:0] prof_wr_idx = '0, prof_last_idx = 3'd3, prof_rep_idx = 3'd2;
  logic [LW-1:0] prof_wr_len = '0;
  logic snoop_valid = 0;
  logic [AW-1:0] snoop_addr = '0;
  logic alarm;
  logic [1:0] alarm_cause;
  int n_chk = 0, n_bad = 0;
  logic done = 0;

  always #5 clk = ~clk;

  keymon_top #(.ADDR_W(AW), .DEPTH(DEPTH), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .enc_active(enc_active),
    .alarm_clr(alarm_clr), .win_base(BASE), .win_limit(LIM),
    .prof_wr_en(prof_wr_en), .prof_wr_idx(prof_wr_idx), .prof_wr_len(prof_wr_len),
    .prof_last_idx(prof_last_idx), .prof_rep_idx(prof_rep_idx),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .alarm(alarm), .alarm_cause(alarm_cause));

  task automatic chk(input string req, input logic [1:0] exp);
    n_chk++;
    if (alarm_cause !== exp || alarm !== (exp != 2'b00)) begin
      n_bad++;
      $display("FAIL %s: cause=%b alarm=%b expected cause=%b", req, alarm_cause, alarm, exp);
    end
  endtask

  task automatic acc(input logic [AW-1:0] a, input logic en);
    @(negedge clk);
    snoop_valid = 1; snoop_addr = a; enc_active = en;
    @(negedge clk);
    snoop_valid = 0;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      snoop_valid = 0; snoop_addr = BASE;
    end
  endtask

  task automatic run(input logic key, input int n, input logic en);
    for (int i = 0; i < n; i++) acc(key ? BASE + AW'(i) : NK_A, en);
  endtask

  task automatic clear();
    @(negedge clk); alarm_clr = 1;
    @(negedge clk); alarm_clr = 0;
  endtask

  task automatic load(input int idx, input int len);
    @(negedge clk);
    prof_wr_en = 1; prof_wr_idx = IW'(idx); prof_wr_len = LW'(len);
    @(negedge clk);
    prof_wr_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset state", 2'b00);
    rst_n = 1;
    load(0, 3); load(1, 4); load(2, 2); load(3, 10);
    mon_en = 1;

    // R2, R5, R3: segment table walk
    for (int s = 0; s < NSEG; s++) begin
      run(SEG[s][11], int'(SEG[s][10:3]), SEG[s][2]);
      chk($sformatf("R2/R5/R3 segment %0d", s), SEG[s][1:0]);
    end

    // R8: suspended after mismatch, stays set
    run(1'b1, 3, 1'b1);
    chk("R8 suspended and sticky", 2'b01);
    clear();
    chk("R7 clear", 2'b00);

    // R4: non-key run grows past its entry
    run(1'b0, 3, 1'b1); run(1'b1, 4, 1'b1); run(1'b0, 2, 1'b1);
    chk("R4 before overrun", 2'b00);
    acc(NK_A, 1'b1);
    chk("R4 overrun flagged", 2'b01);
    clear();

    // R10: idle gaps inside runs
    for (int i = 0; i < 3; i++) begin acc(NK_A, 1'b1); gap(2); end
    for (int i = 0; i < 4; i++) begin acc(BASE, 1'b1); gap(1); end
    run(1'b0, 2, 1'b1); gap(3); run(1'b1, 10, 1'b1);
    chk("R10 gaps ignored", 2'b00);
    clear();

    // R1 / R6: window edges while idle
    acc(BASE - 1'b1, 1'b0); acc(LIM + 1'b1, 1'b0);
    chk("R1 outside window", 2'b00);
    acc(NK_A, 1'b0);
    acc(LIM, 1'b0);
    chk("R1/R6 limit is key", 2'b10);
    clear();
    acc(BASE, 1'b0);
    chk("R1/R7 base key plus early key run", 2'b11);
    clear();

    // R7 / R8: event in clear cycle kept, access ignored by sequence
    @(negedge clk);
    alarm_clr = 1; snoop_valid = 1; snoop_addr = BASE; enc_active = 0;
    @(negedge clk);
    alarm_clr = 0; snoop_valid = 0;
    chk("R7 event in clear cycle", 2'b10);
    run(1'b0, 3, 1'b1); run(1'b1, 4, 1'b1); run(1'b0, 1, 1'b1);
    chk("R8 restart at entry 0", 2'b10);
    clear();

    // R9: monitoring off
    mon_en = 0;
    run(1'b1, 3, 1'b0);
    chk("R9 disabled ignores", 2'b00);
    mon_en = 1;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule